// File: doc/BRIEF.md
# Pad Output Routing Matrix

This block decides, for every pad in a parameterised group (40 by default), which value the pad drives and whether its driver is on. Software reaches it through a plain address / write-strobe / write-data port with a combinational read-data return. Two bit registers are kept per 32-pad bank: a direct output value and a direct output enable. Besides a plain write, each can be modified through a set alias (ones are ORed in) or a clear alias (ones are removed), so single pads can be changed without a read-modify-write.

Each pad also has a configuration word. Its 9-bit selector either names one of the peripheral output signals (each of which brings its own enable) or, with the top bit set, names the pad's own bit in the direct registers. The word can invert the data, invert the final enable, force the enable to come from the direct enable register even when a peripheral drives the data, and put the pad in open-drain mode, in which the driver is only on while the pad is low. The pad outputs are combinational functions of the stored state and the peripheral inputs.

Top module: `gpio_out_matrix`

## Requirements
- R1: After a synchronous reset, both direct registers of every bank read 0 and every configuration word reads 0x100 (selector 256, all flags clear), so every pad has `pad_out` = 0 and `pad_oe` = 0.
- R2: Bit-register addresses below `CFG_BASE` decode as addr[1:0] = operation (0 plain write, 1 set, 2 clear, 3 unmapped), addr[2] = register (0 value, 1 enable), addr[ADDR_W-1:3] = bank; bank b holds pads 32b upward. A plain write stores the data bits that map to pads; a read of operations 0, 1 or 2 returns the register, and bits above the last pad of the top bank read 0.
- R3: A write to a set alias ORs the written ones into the addressed register and leaves bits written as 0 unchanged.
- R4: A write to a clear alias clears the bits written as 1 and leaves bits written as 0 unchanged.
- R5: A write becomes visible on the clock edge that samples the strobe; before that edge a read returns the old contents, and without a write no stored bit changes.
- R6: The configuration word of pad p sits at address `CFG_BASE`+p, with selector in bits 8:0, data invert in bit 9, enable override in bit 10, enable invert in bit 11 and open-drain in bit 12; it reads back as written with bits 31:13 as 0.
- R7: A selector below `NUM_SIGS` drives the pad from `periph_out[sel]` and takes the enable from `periph_oe[sel]`.
- R8: A selector with bit 8 set (256 to 511) drives the pad's bit of the direct value register and takes the enable from the pad's bit of the direct enable register.
- R9: A selector from `NUM_SIGS` to 255 gives data 0 and a peripheral enable of 0.
- R10: With data invert set, the pad drives the complement of the selected data.
- R11: With enable override set, the enable comes from the direct enable register even when a peripheral is selected.
- R12: With enable invert set, the enable after source selection is complemented.
- R13: With open-drain set, `pad_out` is the final data and `pad_oe` is the final enable ANDed with the complement of that data; with it clear `pad_oe` is the final enable.
- R14: Writes to unmapped addresses (operation 3, a bank above the last, or a configuration address past the last pad) change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word address for reads and writes |
| reg_wen | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| periph_out | input | NUM_SIGS | Peripheral output data signals |
| periph_oe | input | NUM_SIGS | Peripheral output enable signals |
| pad_out | output | NUM_PADS | Value driven to each pad |
| pad_oe | output | NUM_PADS | Driver enable of each pad |

## Verification
The bench runs with fewer peripheral signals than selector codes, so the gap between the last real signal and code 255 exists; a design that indexed past the end or wrapped the selector would drive a live peripheral there instead of a quiet 0. One pad is swept over all 512 selector codes, and every pad over all sixteen flag combinations, which catches an override that also moves the data, an enable invert applied before the source choice, or open-drain that ignores inversion. The partial top bank is written with all ones to expose reserved bits that store or read back, and the set and clear aliases are driven with mixed patterns so a plain write posing as an alias shows up. A read taken in the same cycle as the write strobe catches a register that updates too early.

// File: rtl/gpio_mx_pkg.sv
package gpio_mx_pkg;

    localparam int SEL_W  = 9;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } bit_op_e;

    // Field order fixes the software-visible layout: sel[8:0], inv[9], ovr[10], oeinv[11], od[12]
    typedef struct packed {
        logic             od;
        logic             oe_inv;
        logic             oe_ovr;
        logic             d_inv;
        logic [SEL_W-1:0] sel;
    } pad_cfg_t;

    localparam int CFG_W = $bits(pad_cfg_t);

    localparam pad_cfg_t CFG_RESET = '{
        od:     1'b0,
        oe_inv: 1'b0,
        oe_ovr: 1'b0,
        d_inv:  1'b0,
        sel:    9'h100
    };

    function automatic logic [WORD_W-1:0] apply_op(
        input bit_op_e           op,
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wd
    );
        case (op)
            OP_WRITE: return wd;
            OP_SET:   return cur | wd;
            OP_CLEAR: return cur & ~wd;
            default:  return cur;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input pad_cfg_t c);
        return {{(WORD_W-CFG_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/gpio_mx_bitreg.sv
module gpio_mx_bitreg
    import gpio_mx_pkg::*;
#(
    parameter int NUM_PADS = 40,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wen,
    input  logic [WORD_W-1:0]   wdata,
    output logic [NUM_PADS-1:0] dout_q,
    output logic [NUM_PADS-1:0] oe_q,
    output logic                rd_hit,
    output logic [WORD_W-1:0]   rd_word
);

    localparam int NBANK = (NUM_PADS + WORD_W - 1) / WORD_W;

    logic [WORD_W-1:0] v_word [NBANK];
    logic [WORD_W-1:0] e_word [NBANK];

    bit_op_e op;
    logic    op_ok;

    assign op    = bit_op_e'(addr[1:0]);
    assign op_ok = (op != OP_NONE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam int LO = b * WORD_W;
        localparam int BW = (NUM_PADS - LO > WORD_W) ? WORD_W : NUM_PADS - LO;

        logic          bank_sel;
        logic          hit_v;
        logic          hit_e;
        logic [BW-1:0] v_q;
        logic [BW-1:0] e_q;

        assign bank_sel = (addr[ADDR_W-1:3] == (ADDR_W-3)'(b)) && op_ok;
        assign hit_v    = wen && bank_sel && !addr[2];
        assign hit_e    = wen && bank_sel &&  addr[2];

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= '0;
                e_q <= '0;
            end else begin
                if (hit_v) v_q <= BW'(apply_op(op, WORD_W'(v_q), wdata));
                if (hit_e) e_q <= BW'(apply_op(op, WORD_W'(e_q), wdata));
            end
        end

        assign dout_q[LO +: BW] = v_q;
        assign oe_q[LO +: BW]   = e_q;
        assign v_word[b]        = WORD_W'(v_q);
        assign e_word[b]        = WORD_W'(e_q);
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_word = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (addr[ADDR_W-1:3] == (ADDR_W-3)'(b) && op_ok) begin
                rd_hit  = 1'b1;
                rd_word = addr[2] ? e_word[b] : v_word[b];
            end
        end
    end

endmodule

// File: rtl/gpio_mx_cfg.sv
module gpio_mx_cfg
    import gpio_mx_pkg::*;
#(
    parameter int NUM_PADS = 40,
    parameter int ADDR_W   = 8,
    parameter int CFG_BASE = 64
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wen,
    input  logic [WORD_W-1:0]           wdata,
    output pad_cfg_t [NUM_PADS-1:0]     cfg_q,
    output logic                        rd_hit,
    output logic [WORD_W-1:0]           rd_word
);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_word
        logic hit;

        assign hit = wen && (addr == ADDR_W'(CFG_BASE + p));

        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[p] <= CFG_RESET;
            end else if (hit) begin
                cfg_q[p] <= pad_cfg_t'(wdata[CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        rd_hit  = 1'b0;
        rd_word = '0;
        for (int p = 0; p < NUM_PADS; p++) begin
            if (addr == ADDR_W'(CFG_BASE + p)) begin
                rd_hit  = 1'b1;
                rd_word = cfg_to_word(cfg_q[p]);
            end
        end
    end

endmodule

// File: rtl/gpio_mx_pad.sv
module gpio_mx_pad
    import gpio_mx_pkg::*;
#(
    parameter int NUM_SIGS = 256
) (
    input  pad_cfg_t            cfg,
    input  logic [NUM_SIGS-1:0] periph_out,
    input  logic [NUM_SIGS-1:0] periph_oe,
    input  logic                reg_dout,
    input  logic                reg_oe,
    output logic                pad_out,
    output logic                pad_oe
);

    logic sig_d;
    logic sig_e;
    logic use_reg;
    logic d_sel;
    logic d_fin;
    logic e_raw;
    logic e_fin;

    // Codes past the last peripheral match nothing and leave data and enable at 0
    always_comb begin
        sig_d = 1'b0;
        sig_e = 1'b0;
        for (int i = 0; i < NUM_SIGS; i++) begin
            if (cfg.sel == SEL_W'(i)) begin
                sig_d = periph_out[i];
                sig_e = periph_oe[i];
            end
        end
    end

    always_comb begin
        use_reg = cfg.sel[SEL_W-1];
        d_sel   = use_reg ? reg_dout : sig_d;
        d_fin   = d_sel ^ cfg.d_inv;
        e_raw   = (use_reg || cfg.oe_ovr) ? reg_oe : sig_e;
        e_fin   = e_raw ^ cfg.oe_inv;
        pad_out = d_fin;
        pad_oe  = cfg.od ? (e_fin & ~d_fin) : e_fin;
    end

endmodule

// File: rtl/gpio_out_matrix.sv
module gpio_out_matrix
    import gpio_mx_pkg::*;
#(
    parameter int NUM_PADS = 40,
    parameter int NUM_SIGS = 256,
    parameter int ADDR_W   = 8,
    parameter int CFG_BASE = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wen,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_SIGS-1:0] periph_out,
    input  logic [NUM_SIGS-1:0] periph_oe,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe
);

    logic [NUM_PADS-1:0]     dout_q;
    logic [NUM_PADS-1:0]     oe_q;
    logic [NUM_PADS-1:0]     od_mask;
    pad_cfg_t [NUM_PADS-1:0] cfg_q;

    logic              bit_hit;
    logic [WORD_W-1:0] bit_word;
    logic              cfg_hit;
    logic [WORD_W-1:0] cfg_word;

    gpio_mx_bitreg #(
        .NUM_PADS (NUM_PADS),
        .ADDR_W   (ADDR_W)
    ) u_bitreg (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wen     (reg_wen),
        .wdata   (reg_wdata),
        .dout_q  (dout_q),
        .oe_q    (oe_q),
        .rd_hit  (bit_hit),
        .rd_word (bit_word)
    );

    gpio_mx_cfg #(
        .NUM_PADS (NUM_PADS),
        .ADDR_W   (ADDR_W),
        .CFG_BASE (CFG_BASE)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .addr    (reg_addr),
        .wen     (reg_wen),
        .wdata   (reg_wdata),
        .cfg_q   (cfg_q),
        .rd_hit  (cfg_hit),
        .rd_word (cfg_word)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpio_mx_pad #(
            .NUM_SIGS (NUM_SIGS)
        ) u_pad (
            .cfg        (cfg_q[p]),
            .periph_out (periph_out),
            .periph_oe  (periph_oe),
            .reg_dout   (dout_q[p]),
            .reg_oe     (oe_q[p]),
            .pad_out    (pad_out[p]),
            .pad_oe     (pad_oe[p])
        );
        assign od_mask[p] = cfg_q[p].od;
    end

    always_comb begin
        if (bit_hit)      reg_rdata = bit_word;
        else if (cfg_hit) reg_rdata = cfg_word;
        else              reg_rdata = '0;
    end

endmodule

// File: rtl/gpio_mx_chk.sv
module gpio_mx_chk #(
    parameter int NUM_PADS = 40,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wen,
    input logic [31:0]         reg_wdata,
    input logic [31:0]         reg_rdata,
    input logic [NUM_PADS-1:0] pad_out,
    input logic [NUM_PADS-1:0] pad_oe,
    input logic [NUM_PADS-1:0] dout_q,
    input logic [NUM_PADS-1:0] oe_q,
    input logic [NUM_PADS-1:0] od_mask
);

    localparam int NBANK   = (NUM_PADS + 31) / 32;
    localparam int BW0     = (NUM_PADS > 32) ? 32 : NUM_PADS;
    localparam int HI_BITS = NUM_PADS - 32 * (NBANK - 1);

    // R3
    val_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == ADDR_W'(1)) |=>
        dout_q[BW0-1:0] == ($past(dout_q[BW0-1:0]) | $past(reg_wdata[BW0-1:0])));

    // R3
    oe_set_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == ADDR_W'(5)) |=>
        oe_q[BW0-1:0] == ($past(oe_q[BW0-1:0]) | $past(reg_wdata[BW0-1:0])));

    // R4
    val_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wen && reg_addr == ADDR_W'(2)) |=>
        dout_q[BW0-1:0] == ($past(dout_q[BW0-1:0]) & ~$past(reg_wdata[BW0-1:0])));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_wen |=> ($stable(dout_q) && $stable(oe_q)));

    // R13
    open_drain_chk: assert property (@(posedge clk) disable iff (rst)
        (od_mask & pad_out & pad_oe) == '0);

    if (HI_BITS < 32) begin : g_hi
        // R2
        reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (reg_addr == ADDR_W'((NBANK - 1) * 8)) |-> reg_rdata[31:HI_BITS] == '0);
    end

endmodule

bind gpio_out_matrix gpio_mx_chk #(
    .NUM_PADS (NUM_PADS),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .dout_q    (dout_q),
    .oe_q      (oe_q),
    .od_mask   (od_mask)
);

// File: tb/gpio_out_matrix_tb.sv
module gpio_out_matrix_tb_top;

    localparam int NP   = 40;
    localparam int NS   = 16;
    localparam int AW   = 8;
    localparam int CB   = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wen = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] periph_out = '0;
    logic [NS-1:0] periph_oe = '0;
    logic [NP-1:0] pad_out;
    logic [NP-1:0] pad_oe;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [NP-1:0] m_dout = '0;
    logic [NP-1:0] m_oe   = '0;
    logic [12:0]   m_cfg [NP];

    always #2 clk = ~clk;

    gpio_out_matrix #(
        .NUM_PADS (NP),
        .NUM_SIGS (NS),
        .ADDR_W   (AW),
        .CFG_BASE (CB)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_wen    (reg_wen),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .periph_out (periph_out),
        .periph_oe  (periph_oe),
        .pad_out    (pad_out),
        .pad_oe     (pad_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(posedge clk);
        #1;
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Pad model from the requirements: returns {data, enable}
    function automatic logic [1:0] ref_pad(input logic [12:0] c, input logic [NS-1:0] po,
                                           input logic [NS-1:0] pe, input logic rd_v,
                                           input logic re_v);
        logic [8:0] s;
        logic       d;
        logic       e;
        s = c[8:0];
        if (s[8]) begin            // R8
            d = rd_v;
            e = re_v;
        end else if (s < NS) begin // R7
            d = po[s[3:0]];
            e = pe[s[3:0]];
        end else begin             // R9
            d = 1'b0;
            e = 1'b0;
        end
        if (c[10]) e = re_v;       // R11
        d = d ^ c[9];              // R10
        e = e ^ c[11];             // R12
        if (c[12]) e = e & ~d;     // R13
        return {d, e};
    endfunction

    function automatic string sel_tag(input logic [8:0] s);
        if (s[8])   return "R8";
        if (s < NS) return "R7";
        return "R9";
    endfunction

    task automatic check_pad(input string req, input int p);
        logic [1:0] e;
        e = ref_pad(m_cfg[p], periph_out, periph_oe, m_dout[p], m_oe[p]);
        check(req, {30'd0, pad_out[p], pad_oe[p]}, {30'd0, e});
    endtask

    task automatic set_cfg(input int p, input logic [12:0] c);
        wr(AW'(CB + p), {19'd0, c});
        m_cfg[p] = c;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int p = 0; p < NP; p++) m_cfg[p] = 13'h100;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(8'd0, d);  check("R1 value bank0", d, 32'h0);
        rd(8'd4, d);  check("R1 enable bank0", d, 32'h0);
        rd(8'd8, d);  check("R1 value bank1", d, 32'h0);
        rd(8'd12, d); check("R1 enable bank1", d, 32'h0);
        rd(8'(CB), d);      check("R1 cfg pad0", d, 32'h100);
        rd(8'(CB + 39), d); check("R1 cfg pad39", d, 32'h100);
        check("R1 pad_oe", 32'(pad_oe[31:0]) | 32'(pad_oe[39:32]), 32'h0);
        check("R1 pad_out", 32'(pad_out[31:0]) | 32'(pad_out[39:32]), 32'h0);

        // R2: plain writes, partial top bank
        wr(8'd0, 32'hA5A5_1234);  rd(8'd0, d);  check("R2 value bank0", d, 32'hA5A5_1234);
        wr(8'd8, 32'hFFFF_FFFF);  rd(8'd8, d);  check("R2 value bank1 reserved", d, 32'h0000_00FF);
        wr(8'd4, 32'h0F0F_00FF);  rd(8'd4, d);  check("R2 enable bank0", d, 32'h0F0F_00FF);
        wr(8'd12, 32'hFFFF_FF3C); rd(8'd12, d); check("R2 enable bank1 reserved", d, 32'h0000_003C);
        rd(8'd9, d); check("R2 read via set alias", d, 32'h0000_00FF);

        // R3: set aliases
        wr(8'd1, 32'h0000_F00F);  rd(8'd0, d);  check("R3 set value bank0", d, 32'hA5A5_F23F);
        wr(8'd5, 32'h8000_0100);  rd(8'd4, d);  check("R3 set enable bank0", d, 32'h8F0F_01FF);
        wr(8'd13, 32'hFFFF_FF41); rd(8'd12, d); check("R3 set enable bank1", d, 32'h0000_007D);

        // R4: clear aliases
        wr(8'd2, 32'h0000_0F0F);  rd(8'd0, d);  check("R4 clear value bank0", d, 32'hA5A5_F030);
        wr(8'd10, 32'h0000_00F0); rd(8'd8, d);  check("R4 clear value bank1", d, 32'h0000_000F);
        wr(8'd6, 32'hFFFF_0000);  rd(8'd4, d);  check("R4 clear enable bank0", d, 32'h0000_01FF);

        // R5: write visible only after the sampling edge
        @(negedge clk);
        reg_addr = 8'd0; reg_wdata = 32'h1357_9BDF; reg_wen = 1'b1;
        #1 check("R5 old value before edge", reg_rdata, 32'hA5A5_F030);
        @(posedge clk);
        #1 reg_wen = 1'b0;
        check("R5 new value after edge", reg_rdata, 32'h1357_9BDF);

        // R14: unmapped writes ignored, reads zero
        wr(8'd3, 32'hFFFF_FFFF);  rd(8'd0, d); check("R14 op3 no effect", d, 32'h1357_9BDF);
        rd(8'd3, d);  check("R14 op3 reads zero", d, 32'h0);
        wr(8'd16, 32'hFFFF_FFFF); rd(8'd16, d); check("R14 missing bank reads zero", d, 32'h0);
        rd(8'd0, d);  check("R14 missing bank no alias", d, 32'h1357_9BDF);
        wr(8'(CB + NP), 32'hFFFF_FFFF); rd(8'(CB + NP), d); check("R14 cfg past end", d, 32'h0);
        rd(8'(CB + NP - 1), d); check("R14 last cfg untouched", d, 32'h100);

        // R6: config field layout and reserved bits
        wr(8'(CB + 7), 32'hFFFF_FFFF); m_cfg[7] = 13'h1FFF;
        rd(8'(CB + 7), d); check("R6 cfg all ones", d, 32'h0000_1FFF);
        set_cfg(7, 13'h0A5A); rd(8'(CB + 7), d); check("R6 cfg pattern", d, 32'h0000_0A5A);

        // Known direct registers for routing
        wr(8'd0, 32'h5A3C_96E1);  m_dout[31:0]  = 32'h5A3C_96E1;
        wr(8'd8, 32'h0000_00C5);  m_dout[39:32] = 8'hC5;
        wr(8'd4, 32'h3D1E_87B4);  m_oe[31:0]    = 32'h3D1E_87B4;
        wr(8'd12, 32'h0000_006A); m_oe[39:32]   = 8'h6A;
        periph_out = 16'hB38E;
        periph_oe  = 16'h6D59;

        // Targeted flag checks on pad 3 selecting peripheral 1 (data 1, enable 0)
        set_cfg(3, 13'h0001); #1 check_pad("R7 peripheral route", 3);
        set_cfg(3, 13'h0201); #1 check_pad("R10 data invert", 3);
        set_cfg(3, 13'h0401); #1 check_pad("R11 enable override", 3);
        set_cfg(3, 13'h0801); #1 check_pad("R12 enable invert", 3);
        set_cfg(3, 13'h1801); #1 check_pad("R13 open drain releases high", 3);
        set_cfg(3, 13'h1A01); #1 check_pad("R13 open drain drives low", 3);
        set_cfg(3, 13'h0100); #1 check_pad("R8 register route", 3);
        set_cfg(3, 13'h0014); #1 check_pad("R9 out of range", 3);

        // Sweep: every pad, all flag combinations, selectors across the ranges
        for (int p = 0; p < NP; p++) begin
            for (int f = 0; f < 16; f++) begin
                for (int k = 0; k < 5; k++) begin
                    logic [8:0] s;
                    case (k)
                        0: s = 9'(p % NS);
                        1: s = 9'd256;
                        2: s = 9'(NS + p);
                        3: s = 9'd255;
                        default: s = 9'(257 + p);
                    endcase
                    set_cfg(p, {4'(f), s});
                    #1 check_pad(sel_tag(s), p);
                end
            end
        end

        // Every selector code on a top-bank pad
        for (int s = 0; s < 512; s++) begin
            set_cfg(37, {4'd0, 9'(s)});
            #1 check_pad(sel_tag(9'(s)), 37);
        end

        // Peripheral inputs change, config untouched: routing follows combinationally (R7)
        for (int p = 0; p < NP; p++) set_cfg(p, {4'(p % 16), 9'(p % NS)});
        periph_out = ~16'hB38E;
        periph_oe  = 16'h92A6;
        #1;
        for (int p = 0; p < NP; p++) check_pad("R7 live inputs", p);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule